// File: doc/BRIEF.md
# Interrupt Controller Base Register Mode Machine

This block holds the 64-bit base/enable register of one local interrupt controller. It accepts or refuses writes to that register so that the controller only ever moves between three legal modes: off, legacy-enabled and extended-enabled. Whenever the controller enters extended mode, the block derives the extended logical ID from the controller's initial ID.

A write is offered on a valid/ready pair. Ready is low while reset is held and high from the first clock edge after reset is released. There is no back-pressure beyond that: a write is taken on every edge where valid and ready are both high. A refused write changes nothing and raises a one-cycle error. The block also keeps the 8-bit legacy ID. Software may change that ID outside extended mode, and every base write puts it back to the initial ID.

The bit positions inside the base value are behavioural: enable is bit 11, extended is bit 10, bootstrap-processor is bit 8, and the base address is bits 31:12.

Top module: `irq_base_ctrl`

## Requirements
- R1: After reset, base_q is 0xFEE00900 (address 0xFEE00, enable=1, bootstrap=1), mode is legacy (1), wr_err and sv_en_clr are 0, legacy_id is init_id[7:0] and ext_ldr is 0.
- R2: A write with bit 10 set is refused when ext_supported is 0.
- R3: A write with bit 10 set and bit 11 clear is refused, so base_q never holds extended=1 with enable=0.
- R4: From off mode (bits 11 and 10 both 0), a write with bits 11 and 10 both set is refused.
- R5: From extended mode, a write with bit 11 set and bit 10 clear is refused.
- R6: An accepted write loads bits 31:12 from the data, keeps the bootstrap bit, takes enable and extended from data bits 11 and 10, and clears every other bit. The new value appears in the cycle after the handshake. mode encodes off=0, legacy=1, extended=2.
- R7: A refused write leaves base_q, mode and ext_ldr unchanged and drives wr_err high for exactly the cycle after the handshake.
- R8: On an accepted move from legacy to extended, ext_ldr becomes {init_id[19:4], one-hot of init_id[3:0]} in 32 bits.
- R9: Any handshaked base write, accepted or refused, restores legacy_id to init_id[7:0]. It wins over an ID write in the same cycle.
- R10: An ID write (id_wr_valid) loads legacy_id from id_wr_data when mode is not extended. In extended mode it is ignored.
- R11: An accepted write with bit 11 clear drives sv_en_clr high for one cycle, so the spurious-vector software enable is cleared.
- R12: id_cfg_err is high exactly when init_id is 255 or more and ext_supported is 0.
- R13: wr_ready is low during reset and high from the first edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_supported | input | 1 | Extended mode is supported (static) |
| init_id | input | 32 | Controller initial ID |
| wr_valid | input | 1 | Base write offered |
| wr_ready | output | 1 | Base write can be taken |
| wr_data | input | 64 | Base write value |
| id_wr_valid | input | 1 | Legacy ID write strobe |
| id_wr_data | input | 8 | Legacy ID write value |
| base_q | output | 64 | Current base register |
| mode | output | 2 | Current mode (0 off, 1 legacy, 2 extended) |
| wr_err | output | 1 | One-cycle pulse for a refused write |
| sv_en_clr | output | 1 | One-cycle pulse: clear spurious-vector software enable |
| legacy_id | output | 8 | Current legacy 8-bit ID |
| ext_ldr | output | 32 | Extended logical ID |
| id_cfg_err | output | 1 | Initial ID needs extended support that is absent |

## Verification
A base write and a legacy-ID write can land on the same clock edge, and the ID-restore rule must then beat the ID write. The bench modifies the ID while the controller is off. It then drives both strobes together with a base write that is refused (off straight to extended). It expects legacy_id to return to the initial ID's low byte and wr_err to pulse in the same cycle.

// File: rtl/irq_base_pkg.sv
package irq_base_pkg;
  localparam int EN_BIT  = 11;
  localparam int EXT_BIT = 10;
  localparam int BSP_BIT = 8;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_LEGACY = 2'd1,
    MODE_EXT    = 2'd2,
    MODE_BAD    = 2'd3
  } ctl_mode_e;

  function automatic ctl_mode_e mode_of(input logic en, input logic ext);
    if (!en && !ext)     return MODE_OFF;
    else if (en && !ext) return MODE_LEGACY;
    else if (en && ext)  return MODE_EXT;
    else                 return MODE_BAD;
  endfunction
endpackage

// File: rtl/irq_base_check.sv
module irq_base_check
  import irq_base_pkg::*;
#(
  parameter int BASE_W = 64
) (
  input  logic [BASE_W-1:0] cur,
  input  logic [BASE_W-1:0] wdata,
  input  logic              ext_supported,
  output logic              reject
);
  logic cur_en, cur_ext, new_en, new_ext;
  logic bad_support, bad_state, bad_jump, bad_fallback;

  assign cur_en  = cur[EN_BIT];
  assign cur_ext = cur[EXT_BIT];
  assign new_en  = wdata[EN_BIT];
  assign new_ext = wdata[EXT_BIT];

  always_comb begin
    bad_support  = new_ext && !ext_supported;
    bad_state    = new_ext && !new_en;
    bad_jump     = !cur_en && !cur_ext && new_en && new_ext;
    bad_fallback = cur_en && cur_ext && new_en && !new_ext;
    reject       = bad_support || bad_state || bad_jump || bad_fallback;
  end
endmodule

// File: rtl/irq_base_next.sv
module irq_base_next
  import irq_base_pkg::*;
#(
  parameter int BASE_W  = 64,
  parameter int ADDR_LO = 12,
  parameter int ADDR_HI = 31
) (
  input  logic [BASE_W-1:0] cur,
  input  logic [BASE_W-1:0] wdata,
  output logic [BASE_W-1:0] nxt,
  output logic              enter_ext,
  output logic              disabling
);
  always_comb begin
    nxt                   = '0;
    nxt[ADDR_HI:ADDR_LO]  = wdata[ADDR_HI:ADDR_LO];
    nxt[BSP_BIT]          = cur[BSP_BIT];
    nxt[EN_BIT]           = wdata[EN_BIT];
    nxt[EXT_BIT]          = wdata[EXT_BIT];
    enter_ext             = !cur[EXT_BIT] && wdata[EXT_BIT];
    disabling             = !wdata[EN_BIT];
  end
endmodule

// File: rtl/irq_ldr_calc.sv
module irq_ldr_calc #(
  parameter int ID_W      = 32,
  parameter int LDR_W     = 32,
  parameter int MEMBER_W  = 4,
  parameter int LEGACY_LIM = 255
) (
  input  logic [ID_W-1:0]  init_id,
  input  logic             ext_supported,
  output logic [LDR_W-1:0] ldr,
  output logic             cfg_err
);
  localparam int MEMBERS = 1 << MEMBER_W;
  localparam int HALF    = LDR_W / 2;

  logic [HALF-1:0] member_mask;

  for (genvar g = 0; g < HALF; g++) begin : g_member
    if (g < MEMBERS) begin : g_live
      assign member_mask[g] = (init_id[MEMBER_W-1:0] == MEMBER_W'(g));
    end else begin : g_dead
      assign member_mask[g] = 1'b0;
    end
  end

  assign ldr     = {init_id[MEMBER_W +: HALF], member_mask};
  assign cfg_err = (init_id >= ID_W'(LEGACY_LIM)) && !ext_supported;
endmodule

// File: rtl/irq_base_ctrl.sv
module irq_base_ctrl
  import irq_base_pkg::*;
#(
  parameter int          BASE_W     = 64,
  parameter int          ID_W       = 32,
  parameter int          LID_W      = 8,
  parameter int          LDR_W      = 32,
  parameter int          ADDR_LO    = 12,
  parameter int          ADDR_HI    = 31,
  parameter logic [19:0] RESET_ADDR = 20'hFEE00,
  parameter bit          RESET_BSP  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_supported,
  input  logic [ID_W-1:0]   init_id,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [BASE_W-1:0] wr_data,
  input  logic              id_wr_valid,
  input  logic [LID_W-1:0]  id_wr_data,
  output logic [BASE_W-1:0] base_q,
  output logic [1:0]        mode,
  output logic              wr_err,
  output logic              sv_en_clr,
  output logic [LID_W-1:0]  legacy_id,
  output logic [LDR_W-1:0]  ext_ldr,
  output logic              id_cfg_err
);
  localparam int ADDR_W = ADDR_HI - ADDR_LO + 1;

  logic [BASE_W-1:0] reset_val;
  logic [BASE_W-1:0] nxt_val;
  logic [LDR_W-1:0]  ldr_val;
  logic              reject, enter_ext, disabling, take;
  logic              rdy_q;

  always_comb begin
    reset_val                  = '0;
    reset_val[ADDR_HI:ADDR_LO] = ADDR_W'(RESET_ADDR);
    reset_val[EN_BIT]          = 1'b1;
    reset_val[BSP_BIT]         = RESET_BSP;
  end

  irq_base_check #(.BASE_W(BASE_W)) u_check (
    .cur(base_q), .wdata(wr_data), .ext_supported(ext_supported), .reject(reject)
  );

  irq_base_next #(.BASE_W(BASE_W), .ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI)) u_next (
    .cur(base_q), .wdata(wr_data), .nxt(nxt_val),
    .enter_ext(enter_ext), .disabling(disabling)
  );

  irq_ldr_calc #(.ID_W(ID_W), .LDR_W(LDR_W)) u_ldr (
    .init_id(init_id), .ext_supported(ext_supported),
    .ldr(ldr_val), .cfg_err(id_cfg_err)
  );

  assign take     = wr_valid && rdy_q;
  assign wr_ready = rdy_q;
  assign mode     = mode_of(base_q[EN_BIT], base_q[EXT_BIT]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q     <= 1'b0;
      base_q    <= reset_val;
      wr_err    <= 1'b0;
      sv_en_clr <= 1'b0;
      ext_ldr   <= '0;
      legacy_id <= init_id[LID_W-1:0];
    end else begin
      rdy_q     <= 1'b1;
      wr_err    <= take && reject;
      sv_en_clr <= take && !reject && disabling;
      if (take && !reject) begin
        base_q <= nxt_val;
        if (enter_ext) ext_ldr <= ldr_val;
      end
      if (take) begin
        legacy_id <= init_id[LID_W-1:0];
      end else if (id_wr_valid && !base_q[EXT_BIT]) begin
        legacy_id <= id_wr_data;
      end
    end
  end
endmodule

// File: rtl/irq_base_ctrl_chk.sv
module irq_base_ctrl_chk
  import irq_base_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        ext_supported,
  input logic [31:0] init_id,
  input logic        wr_err,
  input logic [63:0] base_q,
  input logic [1:0]  mode,
  input logic [31:0] ext_ldr
);
  p_reject_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> ($stable(base_q) && $stable(ext_ldr)));

  p_no_off_to_ext_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_OFF) |=> (mode != MODE_EXT));

  p_no_ext_to_legacy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_EXT) |=> (mode != MODE_LEGACY));

  p_no_bad_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(base_q[EXT_BIT] && !base_q[EN_BIT]));

  p_ext_needs_support_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode == MODE_EXT) |-> $past(ext_supported));

  p_ldr_on_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode == MODE_EXT) |->
      (ext_ldr == {$past(init_id[19:4]), 16'(16'd1 << $past(init_id[3:0]))}));
endmodule

bind irq_base_ctrl irq_base_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ext_supported(ext_supported), .init_id(init_id),
  .wr_err(wr_err), .base_q(base_q), .mode(mode), .ext_ldr(ext_ldr)
);

// File: tb/irq_base_ctrl_tb.sv
module irq_base_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_supported = 1'b1;
  logic [31:0] init_id = 32'h123;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [63:0] wr_data = '0;
  logic        id_wr_valid = 1'b0;
  logic [7:0]  id_wr_data = '0;
  logic [63:0] base_q;
  logic [1:0]  mode;
  logic        wr_err, sv_en_clr, id_cfg_err;
  logic [7:0]  legacy_id;
  logic [31:0] ext_ldr;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  irq_base_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ext_supported(ext_supported), .init_id(init_id),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .id_wr_valid(id_wr_valid), .id_wr_data(id_wr_data),
    .base_q(base_q), .mode(mode), .wr_err(wr_err), .sv_en_clr(sv_en_clr),
    .legacy_id(legacy_id), .ext_ldr(ext_ldr), .id_cfg_err(id_cfg_err)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one cycle of stimulus, sampled at the following falling edge
  task automatic cyc(input bit bw, input logic [63:0] bd, input bit iw,
                     input logic [7:0] id);
    wr_valid = bw; wr_data = bd; id_wr_valid = iw; id_wr_data = id;
    @(negedge clk);
    wr_valid = 1'b0; id_wr_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk(wr_ready == 1'b0, "R13 ready in reset", 64'(wr_ready), 0);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);
    chk(wr_ready == 1'b1, "R13 ready after reset", 64'(wr_ready), 1);
    chk(base_q == 64'hFEE0_0900, "R1 base", base_q, 64'hFEE0_0900);
    chk(mode == 2'd1, "R1 mode", 64'(mode), 1);
    chk(legacy_id == 8'h23 && ext_ldr == 0 && !wr_err && !sv_en_clr,
        "R1 id/ldr/pulses", 64'(legacy_id), 64'h23);
  endtask

  task automatic t_cfg;
    chk(id_cfg_err == 1'b0, "R12 supported", 64'(id_cfg_err), 0);
    ext_supported = 1'b0; #1;
    chk(id_cfg_err == 1'b1, "R12 unsupported big id", 64'(id_cfg_err), 1);
    init_id = 32'h10; #1;
    chk(id_cfg_err == 1'b0, "R12 small id", 64'(id_cfg_err), 0);
    init_id = 32'h123; @(negedge clk);
  endtask

  task automatic t_no_support;
    ext_supported = 1'b0;
    cyc(1, 64'hFEE0_0C00, 0, 0);
    chk(wr_err && base_q == 64'hFEE0_0900, "R2 refused", base_q, 64'hFEE0_0900);
    ext_supported = 1'b1;
    cyc(0, 0, 0, 0);
    chk(!wr_err, "R7 single pulse", 64'(wr_err), 0);
  endtask

  task automatic t_ext_no_en;
    cyc(1, 64'hFEE0_0400, 0, 0);
    chk(wr_err && base_q == 64'hFEE0_0900, "R3 refused", base_q, 64'hFEE0_0900);
  endtask

  task automatic t_legacy_write;
    cyc(1, 64'hFFFF_FFFF_ABCD_EAFF, 0, 0);
    chk(!wr_err && base_q == 64'hABCD_E900, "R6 accepted", base_q, 64'hABCD_E900);
    chk(!sv_en_clr, "R11 no clear", 64'(sv_en_clr), 0);
  endtask

  task automatic t_disable;
    cyc(1, 64'hFEE0_0000, 0, 0);
    chk(base_q == 64'hFEE0_0100 && mode == 2'd0, "R6 disable", base_q, 64'hFEE0_0100);
    chk(sv_en_clr, "R11 clear pulse", 64'(sv_en_clr), 1);
    cyc(0, 0, 0, 0);
    chk(!sv_en_clr, "R11 pulse ends", 64'(sv_en_clr), 0);
  endtask

  task automatic t_off_to_ext;
    cyc(1, 64'hFEE0_0C00, 0, 0);
    chk(wr_err && base_q == 64'hFEE0_0100, "R4 refused", base_q, 64'hFEE0_0100);
    cyc(0, 0, 0, 0);
    chk(!wr_err && base_q == 64'hFEE0_0100, "R7 held", base_q, 64'hFEE0_0100);
  endtask

  task automatic t_id_restore;
    cyc(0, 0, 1, 8'h55);
    chk(legacy_id == 8'h55, "R10 id write when off", 64'(legacy_id), 64'h55);
    cyc(1, 64'hFEE0_0800, 0, 0);
    chk(base_q == 64'hFEE0_0900 && mode == 2'd1, "R6 enable", base_q, 64'hFEE0_0900);
    chk(legacy_id == 8'h23, "R9 restore", 64'(legacy_id), 64'h23);
  endtask

  task automatic t_to_ext;
    cyc(1, 64'hFEE0_0C00, 0, 0);
    chk(base_q == 64'hFEE0_0D00 && mode == 2'd2, "R6 extended", base_q, 64'hFEE0_0D00);
    chk(ext_ldr == 32'h0012_0008, "R8 ldr", 64'(ext_ldr), 64'h0012_0008);
    cyc(0, 0, 1, 8'h77);
    chk(legacy_id == 8'h23, "R10 ignored in ext", 64'(legacy_id), 64'h23);
  endtask

  task automatic t_ext_to_legacy;
    cyc(1, 64'hFEE0_0800, 0, 0);
    chk(wr_err && base_q == 64'hFEE0_0D00, "R5 refused", base_q, 64'hFEE0_0D00);
    chk(ext_ldr == 32'h0012_0008, "R7 ldr kept", 64'(ext_ldr), 64'h0012_0008);
  endtask

  task automatic t_same_cycle;
    cyc(1, 64'hFEE0_0000, 0, 0);
    chk(mode == 2'd0, "R6 ext to off", 64'(mode), 0);
    cyc(0, 0, 1, 8'h44);
    chk(legacy_id == 8'h44, "R10 id write", 64'(legacy_id), 64'h44);
    cyc(1, 64'hFEE0_0C00, 1, 8'h66);
    chk(legacy_id == 8'h23, "R9 base write wins", 64'(legacy_id), 64'h23);
    chk(wr_err && mode == 2'd0, "R4 refused in collision", 64'(mode), 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_cfg();
    t_no_support();
    t_ext_no_en();
    t_legacy_write();
    t_disable();
    t_off_to_ext();
    t_id_restore();
    t_to_ext();
    t_ext_to_legacy();
    t_same_cycle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule